// File: doc/BRIEF.md
# Special Register Move Unit

This unit carries out the special-register instructions of a 32-bit processor core. Each issued instruction arrives as already-split fields: a major opcode, a 5-bit middle field and a 16-bit immediate field. It also arrives with the general-purpose operand and the current program counter. The unit recognises four kinds of operation. A move-to copies the operand into a special register chosen by a 14-bit selector. A move-from returns a special register as a destination result. An upper-half move-from returns bits 63:32 of the few registers that are 64 bits wide. Bit-set and bit-clear operations update the status register from a 14-bit immediate and return its old value.

The selector map is sparse. Some registers can only be written. Others come from the rest of the core as inputs and can only be read: exception address, exception status, branch target and exception data. A third group is a set of version constants taken from a parameter. Every result and every register update lands at the same clock edge. An instruction issued in the cycle after a write therefore sees the new value.

The decoded operation kinds act as the unit's states. OP_IDLE means no operation. OP_PUT is a move-to. OP_GET is a move-from. OP_GETHI is an upper-half move-from. OP_SETB is a bit-set and OP_CLRB is a bit-clear. Each issue moves the result register from its idle value (zero, enable low) to a loaded value for one cycle. When no reading operation is issued, it returns to the idle value.

Top module: `srm_unit`

## Requirements
- R1: An operation counts only when i_valid is high and i_major equals 6'b100101. Any other combination leaves every register output unchanged and gives o_rd_we low. This includes i_imm[15:14] = 2'b01, a middle field other than 5'b00000 or 5'b01000 with prefix 2'b10, and a middle field other than 5'b00000 or 5'b00001 with prefix 2'b00.
- R2: Prefix i_imm[15:14] = 2'b11 is a move-to, and the selector is i_imm[13:0]. The operand i_ra is written into the register with that selector. The selectors are 0x0001 status, 0x0007 float status, 0x0800 stack low, 0x0802 stack high, 0x1000 address-space id, 0x1001 zone protection, 0x1002 TLB index, 0x1003 TLB low, 0x1004 TLB high and 0x1005 TLB search.
- R3: A move-to whose selector is read-only (0x0000, 0x0003, 0x0005, 0x000B, 0x000D, 0x2000 upward) or unmapped changes no register.
- R4: Prefix 2'b10 with middle field 5'b00000 is a move-from. Selector 0x0000 returns i_pc. 0x0003 returns i_exc_addr[31:0], 0x0005 returns i_exc_stat, 0x000B returns i_br_tgt and 0x000D returns i_exc_data. The writable registers 0x0001 to 0x1004 return their contents. The write-only 0x1005 and unmapped selectors return zero.
- R5: Move-from selector 0x2000+k, for k below NUM_VER (default 13), returns bits 31:0 of VER_BASE+k. The default VER_BASE is 64'h0003_0010_0A00_0100. The selector 0x2000+NUM_VER returns zero.
- R6: Prefix 2'b10 with middle field 5'b01000 is an upper-half move-from. It returns i_exc_addr[63:32] for 0x0003 and bits 63:32 of VER_BASE+k for 0x2008 and 0x2009. Every other selector returns zero.
- R7: Prefix 2'b00 with middle field 5'b00000 sets bits. o_rd gets the old status, and the status becomes old OR the zero-extended i_imm[13:0].
- R8: Prefix 2'b00 with middle field 5'b00001 clears bits. o_rd gets the old status, and the status becomes old AND NOT the zero-extended i_imm[13:0].
- R9: o_rd and o_rd_we are registered. o_rd_we is high for exactly the cycle after a move-from, upper-half move-from, set or clear, and is low after a move-to. o_rd is zero whenever o_rd_we is low. A move-from issued in the cycle right after a move-to returns the new value.
- R10: During reset every writable register, o_rd and o_rd_we are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_valid | input | 1 | An instruction is issued this cycle |
| i_major | input | 6 | Major opcode field |
| i_mid | input | 5 | Middle field that picks the variant |
| i_imm | input | 16 | Prefix (15:14) and selector or immediate (13:0) |
| i_ra | input | DATA_W | General-purpose operand |
| i_pc | input | DATA_W | Current program counter |
| i_exc_addr | input | 2*DATA_W | Exception address |
| i_exc_stat | input | DATA_W | Exception status |
| i_br_tgt | input | DATA_W | Branch target |
| i_exc_data | input | DATA_W | Exception data |
| o_rd | output | DATA_W | Destination result |
| o_rd_we | output | 1 | Destination write enable |
| o_status | output | DATA_W | Status register |
| o_fpstat | output | DATA_W | Float status register |
| o_stk_lo | output | DATA_W | Stack low limit |
| o_stk_hi | output | DATA_W | Stack high limit |
| o_asid | output | DATA_W | Address-space id |
| o_zprot | output | DATA_W | Zone protection |
| o_tlb_idx | output | DATA_W | TLB index |
| o_tlb_lo | output | DATA_W | TLB low word |
| o_tlb_hi | output | DATA_W | TLB high word |
| o_tlb_srch | output | DATA_W | TLB search (write-only) |

## Verification
The bench aims at the edges of the sparse map.
- It writes to read-only selectors. A design that treated them as writable would disturb some register.
- It reads the write-only TLB search selector and the first selector past the version range. A design with a loose decode would return data there instead of zero.
- It makes upper-half reads outside the three 64-bit selectors, which would otherwise leak the low half.
- It clears and sets with an all-ones immediate. A swapped clear polarity, or a result that shows the new status rather than the old one, then stands out at once.
- It issues move-to and move-from back to back, which exposes a read path that is one cycle late.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int SEL_W    = 14;
    localparam int IMM_W    = 14;
    localparam int OPC_W    = 6;
    localparam int MID_W    = 5;
    localparam int FIELD_W  = 16;
    localparam int NUM_WREG = 10;

    localparam logic [OPC_W-1:0] OPC_SPR   = 6'b100101;
    localparam logic [MID_W-1:0] MID_PLAIN = 5'b00000;
    localparam logic [MID_W-1:0] MID_UPPER = 5'b01000;
    localparam logic [MID_W-1:0] MID_CLEAR = 5'b00001;

    // read-only selectors
    localparam logic [SEL_W-1:0] SEL_PC    = 14'h0000;
    localparam logic [SEL_W-1:0] SEL_EADDR = 14'h0003;
    localparam logic [SEL_W-1:0] SEL_ESTAT = 14'h0005;
    localparam logic [SEL_W-1:0] SEL_BTGT  = 14'h000B;
    localparam logic [SEL_W-1:0] SEL_EDATA = 14'h000D;
    localparam logic [SEL_W-1:0] SEL_VER0  = 14'h2000;
    localparam logic [SEL_W-1:0] SEL_VER8  = 14'h2008;
    localparam logic [SEL_W-1:0] SEL_VER9  = 14'h2009;
    // writable selectors
    localparam logic [SEL_W-1:0] SEL_STAT  = 14'h0001;
    localparam logic [SEL_W-1:0] SEL_FPST  = 14'h0007;
    localparam logic [SEL_W-1:0] SEL_STKLO = 14'h0800;
    localparam logic [SEL_W-1:0] SEL_STKHI = 14'h0802;
    localparam logic [SEL_W-1:0] SEL_ASID  = 14'h1000;
    localparam logic [SEL_W-1:0] SEL_ZPROT = 14'h1001;
    localparam logic [SEL_W-1:0] SEL_TIDX  = 14'h1002;
    localparam logic [SEL_W-1:0] SEL_TLO   = 14'h1003;
    localparam logic [SEL_W-1:0] SEL_THI   = 14'h1004;
    localparam logic [SEL_W-1:0] SEL_TSRCH = 14'h1005;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUT,
        OP_GET,
        OP_GETHI,
        OP_SETB,
        OP_CLRB
    } op_kind_e;

    // slot order of the writable bank; slot 0 is the status register
    function automatic logic [SEL_W-1:0] wsel(input int idx);
        case (idx)
            0:       return SEL_STAT;
            1:       return SEL_FPST;
            2:       return SEL_STKLO;
            3:       return SEL_STKHI;
            4:       return SEL_ASID;
            5:       return SEL_ZPROT;
            6:       return SEL_TIDX;
            7:       return SEL_TLO;
            8:       return SEL_THI;
            default: return SEL_TSRCH;
        endcase
    endfunction

endpackage

// File: rtl/srm_decode.sv
module srm_decode
    import srm_pkg::*;
(
    input  logic               valid,
    input  logic [OPC_W-1:0]   major,
    input  logic [MID_W-1:0]   mid,
    input  logic [FIELD_W-1:0] field,
    output op_kind_e           kind,
    output logic [SEL_W-1:0]   sel
);

    logic [1:0] prefix;

    assign prefix = field[FIELD_W-1 -: 2];
    assign sel    = field[SEL_W-1:0];

    always_comb begin
        kind = OP_IDLE;
        if (valid && (major == OPC_SPR)) begin
            unique case (prefix)
                2'b11: kind = OP_PUT;
                2'b10: begin
                    if (mid == MID_PLAIN)      kind = OP_GET;
                    else if (mid == MID_UPPER) kind = OP_GETHI;
                end
                2'b00: begin
                    if (mid == MID_PLAIN)      kind = OP_SETB;
                    else if (mid == MID_CLEAR) kind = OP_CLRB;
                end
                default: kind = OP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srm_regs.sv
module srm_regs
    import srm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_kind_e          kind,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q [NUM_WREG]
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] nxt [NUM_WREG];
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] stat_nxt;

    assign imm_ext = {{PAD_W{1'b0}}, sel};

    // status slot: move-to, bit set and bit clear all land here
    always_comb begin
        stat_nxt = q[0];
        unique case (kind)
            OP_PUT:  if (sel == SEL_STAT) stat_nxt = wdata;
            OP_SETB: stat_nxt = q[0] | imm_ext;
            OP_CLRB: stat_nxt = q[0] & ~imm_ext;
            default: stat_nxt = q[0];
        endcase
    end

    assign nxt[0] = stat_nxt;

    for (genvar g = 1; g < NUM_WREG; g++) begin : g_slot
        assign nxt[g] = ((kind == OP_PUT) && (sel == wsel(g))) ? wdata : q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WREG; i++) q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_WREG; i++) q[i] <= nxt[i];
        end
    end

endmodule

// File: rtl/srm_rdmux.sv
module srm_rdmux
    import srm_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              NUM_VER  = 13,
    parameter logic [2*DATA_W-1:0] VER_BASE = 64'h0003_0010_0A00_0100
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic                upper,
    input  logic [DATA_W-1:0]   q [NUM_WREG],
    input  logic [DATA_W-1:0]   pc,
    input  logic [2*DATA_W-1:0] exc_addr,
    input  logic [DATA_W-1:0]   exc_stat,
    input  logic [DATA_W-1:0]   br_tgt,
    input  logic [DATA_W-1:0]   exc_data,
    output logic [DATA_W-1:0]   data
);

    localparam int WIDE_W  = 2 * DATA_W;
    localparam int NUM_RDW = NUM_WREG - 1;   // the search slot is write-only

    logic [SEL_W-1:0]  voff;
    logic              vhit;
    logic [WIDE_W-1:0] ver;
    logic [DATA_W-1:0] bank;
    logic              bank_hit;

    assign voff = sel - SEL_VER0;
    assign vhit = (sel >= SEL_VER0) && (voff < SEL_W'(NUM_VER));
    assign ver  = VER_BASE + WIDE_W'(voff);

    always_comb begin
        bank     = '0;
        bank_hit = 1'b0;
        for (int k = 0; k < NUM_RDW; k++) begin
            if (sel == wsel(k)) begin
                bank     = q[k];
                bank_hit = 1'b1;
            end
        end
    end

    always_comb begin
        data = '0;
        if (upper) begin
            if (sel == SEL_EADDR)
                data = exc_addr[WIDE_W-1:DATA_W];
            else if (((sel == SEL_VER8) || (sel == SEL_VER9)) && vhit)
                data = ver[WIDE_W-1:DATA_W];
        end else begin
            unique case (sel)
                SEL_PC:    data = pc;
                SEL_EADDR: data = exc_addr[DATA_W-1:0];
                SEL_ESTAT: data = exc_stat;
                SEL_BTGT:  data = br_tgt;
                SEL_EDATA: data = exc_data;
                default: begin
                    if (bank_hit)  data = bank;
                    else if (vhit) data = ver[DATA_W-1:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/srm_unit.sv
module srm_unit
    import srm_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              NUM_VER  = 13,
    parameter logic [2*DATA_W-1:0] VER_BASE = 64'h0003_0010_0A00_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_valid,
    input  logic [OPC_W-1:0]    i_major,
    input  logic [MID_W-1:0]    i_mid,
    input  logic [FIELD_W-1:0]  i_imm,
    input  logic [DATA_W-1:0]   i_ra,
    input  logic [DATA_W-1:0]   i_pc,
    input  logic [2*DATA_W-1:0] i_exc_addr,
    input  logic [DATA_W-1:0]   i_exc_stat,
    input  logic [DATA_W-1:0]   i_br_tgt,
    input  logic [DATA_W-1:0]   i_exc_data,
    output logic [DATA_W-1:0]   o_rd,
    output logic                o_rd_we,
    output logic [DATA_W-1:0]   o_status,
    output logic [DATA_W-1:0]   o_fpstat,
    output logic [DATA_W-1:0]   o_stk_lo,
    output logic [DATA_W-1:0]   o_stk_hi,
    output logic [DATA_W-1:0]   o_asid,
    output logic [DATA_W-1:0]   o_zprot,
    output logic [DATA_W-1:0]   o_tlb_idx,
    output logic [DATA_W-1:0]   o_tlb_lo,
    output logic [DATA_W-1:0]   o_tlb_hi,
    output logic [DATA_W-1:0]   o_tlb_srch
);

    op_kind_e          kind;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] regs [NUM_WREG];
    logic [DATA_W-1:0] rdata;

    srm_decode u_dec (
        .valid (i_valid),
        .major (i_major),
        .mid   (i_mid),
        .field (i_imm),
        .kind  (kind),
        .sel   (sel)
    );

    srm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .sel   (sel),
        .wdata (i_ra),
        .q     (regs)
    );

    srm_rdmux #(
        .DATA_W   (DATA_W),
        .NUM_VER  (NUM_VER),
        .VER_BASE (VER_BASE)
    ) u_mux (
        .sel      (sel),
        .upper    (kind == OP_GETHI),
        .q        (regs),
        .pc       (i_pc),
        .exc_addr (i_exc_addr),
        .exc_stat (i_exc_stat),
        .br_tgt   (i_br_tgt),
        .exc_data (i_exc_data),
        .data     (rdata)
    );

    // result register: loaded for one cycle after a reading operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_rd    <= '0;
            o_rd_we <= 1'b0;
        end else begin
            unique case (kind)
                OP_GET, OP_GETHI: begin
                    o_rd    <= rdata;
                    o_rd_we <= 1'b1;
                end
                OP_SETB, OP_CLRB: begin
                    o_rd    <= regs[0];
                    o_rd_we <= 1'b1;
                end
                default: begin
                    o_rd    <= '0;
                    o_rd_we <= 1'b0;
                end
            endcase
        end
    end

    assign o_status   = regs[0];
    assign o_fpstat   = regs[1];
    assign o_stk_lo   = regs[2];
    assign o_stk_hi   = regs[3];
    assign o_asid     = regs[4];
    assign o_zprot    = regs[5];
    assign o_tlb_idx  = regs[6];
    assign o_tlb_lo   = regs[7];
    assign o_tlb_hi   = regs[8];
    assign o_tlb_srch = regs[9];

endmodule

// File: rtl/srm_unit_chk.sv
module srm_unit_chk
    import srm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               i_valid,
    input logic [OPC_W-1:0]   i_major,
    input logic [MID_W-1:0]   i_mid,
    input logic [FIELD_W-1:0] i_imm,
    input logic [DATA_W-1:0]  i_ra,
    input logic [DATA_W-1:0]  o_rd,
    input logic               o_rd_we,
    input logic [DATA_W-1:0]  o_status,
    input logic [DATA_W-1:0]  o_fpstat
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic ok;
    logic is_spr, is_set, is_clr, is_put_stat, is_rdop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok <= 1'b0;
        else        ok <= 1'b1;
    end

    assign is_spr      = i_valid && (i_major == OPC_SPR);
    assign is_set      = is_spr && (i_imm[15:14] == 2'b00) && (i_mid == MID_PLAIN);
    assign is_clr      = is_spr && (i_imm[15:14] == 2'b00) && (i_mid == MID_CLEAR);
    assign is_put_stat = is_spr && (i_imm[15:14] == 2'b11) && (i_imm[13:0] == SEL_STAT);
    assign is_rdop     = is_spr && (i_imm[15:14] != 2'b11);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !$past(i_valid)) |-> (!o_rd_we && $stable(o_status) && $stable(o_fpstat)));

    // R9
    we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && o_rd_we) |-> $past(is_rdop));

    // R9
    rd_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !o_rd_we |-> (o_rd == '0));

    // R2
    status_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $past(is_put_stat)) |-> (o_status == $past(i_ra)));

    // R7
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $past(is_set)) |->
        ((o_status == ($past(o_status) | {{PAD_W{1'b0}}, $past(i_imm[13:0])}))
         && (o_rd == $past(o_status))));

    // R8
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $past(is_clr)) |->
        ((o_status == ($past(o_status) & ~{{PAD_W{1'b0}}, $past(i_imm[13:0])}))
         && (o_rd == $past(o_status))));

endmodule

bind srm_unit srm_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .i_valid  (i_valid),
    .i_major  (i_major),
    .i_mid    (i_mid),
    .i_imm    (i_imm),
    .i_ra     (i_ra),
    .o_rd     (o_rd),
    .o_rd_we  (o_rd_we),
    .o_status (o_status),
    .o_fpstat (o_fpstat)
);

// File: tb/sim_srm_unit.sv
module sim_srm_unit;

    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] VB         = 64'h0003_0010_0A00_0100;
    localparam logic [5:0]  OPC        = 6'b100101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0;
    logic [5:0]  i_major = '0;
    logic [4:0]  i_mid = '0;
    logic [15:0] i_imm = '0;
    logic [31:0] i_ra = '0, i_pc = '0, i_exc_stat = '0, i_br_tgt = '0, i_exc_data = '0;
    logic [63:0] i_exc_addr = '0;
    logic [31:0] o_rd;
    logic        o_rd_we;
    logic [31:0] obs [10];

    int checks = 0;
    int errors = 0;
    logic [31:0] m [10];

    always #(CLK_PERIOD/2) clk = ~clk;

    srm_unit u0 (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_major(i_major), .i_mid(i_mid),
        .i_imm(i_imm), .i_ra(i_ra), .i_pc(i_pc), .i_exc_addr(i_exc_addr),
        .i_exc_stat(i_exc_stat), .i_br_tgt(i_br_tgt), .i_exc_data(i_exc_data),
        .o_rd(o_rd), .o_rd_we(o_rd_we),
        .o_status(obs[0]), .o_fpstat(obs[1]), .o_stk_lo(obs[2]), .o_stk_hi(obs[3]),
        .o_asid(obs[4]), .o_zprot(obs[5]), .o_tlb_idx(obs[6]), .o_tlb_lo(obs[7]),
        .o_tlb_hi(obs[8]), .o_tlb_srch(obs[9])
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int widx(input logic [13:0] s);
        case (s)
            14'h0001: return 0;  14'h0007: return 1;  14'h0800: return 2;
            14'h0802: return 3;  14'h1000: return 4;  14'h1001: return 5;
            14'h1002: return 6;  14'h1003: return 7;  14'h1004: return 8;
            14'h1005: return 9;  default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_low(input logic [13:0] s);
        logic [63:0] v;
        if (s >= 14'h2000 && s < 14'h200D) begin
            v = VB + 64'(s - 14'h2000);
            return v[31:0];
        end
        case (s)
            14'h0000: return i_pc;
            14'h0003: return i_exc_addr[31:0];
            14'h0005: return i_exc_stat;
            14'h000B: return i_br_tgt;
            14'h000D: return i_exc_data;
            14'h1005: return 32'h0;
            default:  return (widx(s) >= 0) ? m[widx(s)] : 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_high(input logic [13:0] s);
        logic [63:0] v;
        v = VB + 64'(s - 14'h2000);
        if (s == 14'h0003) return i_exc_addr[63:32];
        if (s == 14'h2008 || s == 14'h2009) return v[63:32];
        return 32'h0;
    endfunction

    task automatic issue(input logic [5:0] maj, input logic [4:0] mid,
                         input logic [15:0] imm, input logic [31:0] ra, input string tag);
        logic [13:0] s;
        logic [31:0] e_rd;
        logic        e_we;
        int          wi;
        s = imm[13:0];
        i_valid = 1'b1; i_major = maj; i_mid = mid; i_imm = imm; i_ra = ra;
        i_pc = $urandom; i_exc_stat = $urandom; i_br_tgt = $urandom; i_exc_data = $urandom;
        i_exc_addr = {$urandom, $urandom};
        e_rd = 32'h0; e_we = 1'b0;
        if (maj == OPC) begin
            case (imm[15:14])
                2'b11: begin
                    wi = widx(s);
                    if (wi >= 0) m[wi] = ra;
                end
                2'b10: begin
                    if (mid == 5'b00000) begin e_we = 1'b1; e_rd = exp_low(s); end
                    else if (mid == 5'b01000) begin e_we = 1'b1; e_rd = exp_high(s); end
                end
                2'b00: begin
                    if (mid == 5'b00000) begin e_we = 1'b1; e_rd = m[0]; m[0] = m[0] | {18'h0, s}; end
                    else if (mid == 5'b00001) begin e_we = 1'b1; e_rd = m[0]; m[0] = m[0] & ~{18'h0, s}; end
                end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        i_valid = 1'b0;
        chk({tag, " rd"}, o_rd, e_rd);
        chk({tag, " we"}, {31'h0, o_rd_we}, {31'h0, e_we});
        for (int k = 0; k < 10; k++) chk({tag, " state"}, obs[k], m[k]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] pool [24];
        void'($urandom(32'd2718));
        pool = '{14'h0000, 14'h0001, 14'h0003, 14'h0005, 14'h0007, 14'h000B, 14'h000D,
                 14'h0800, 14'h0802, 14'h1000, 14'h1001, 14'h1002, 14'h1003, 14'h1004,
                 14'h1005, 14'h2000, 14'h2005, 14'h2008, 14'h2009, 14'h200C, 14'h200D,
                 14'h0004, 14'h3FFF, 14'h0002};
        for (int k = 0; k < 10; k++) m[k] = 32'h0;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk("R10 rd", o_rd, 32'h0);
        chk("R10 we", {31'h0, o_rd_we}, 32'h0);
        for (int k = 0; k < 10; k++) chk("R10 state", obs[k], 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: every writable selector, each followed at once by a read (R9)
        for (int k = 0; k < 24; k++) begin
            issue(OPC, 5'd0, {2'b11, pool[k]}, 32'hC0DE_0000 + 32'(k), "R2_R3 put");
            issue(OPC, 5'd0, {2'b10, pool[k]}, 32'h0, "R9_R4 get");
        end
        // R5: version range and one past it
        for (int k = 0; k < 14; k++)
            issue(OPC, 5'd0, {2'b10, 14'h2000 + 14'(k)}, 32'h0, "R5 ver");
        // R6: upper-half reads
        issue(OPC, 5'b01000, {2'b10, 14'h0003}, 32'h0, "R6 eaddr");
        issue(OPC, 5'b01000, {2'b10, 14'h2008}, 32'h0, "R6 ver8");
        issue(OPC, 5'b01000, {2'b10, 14'h2009}, 32'h0, "R6 ver9");
        issue(OPC, 5'b01000, {2'b10, 14'h0001}, 32'h0, "R6 status");
        issue(OPC, 5'b01000, {2'b10, 14'h2000}, 32'h0, "R6 ver0");
        // R7 / R8: all-ones immediates and old value in rd
        issue(OPC, 5'd0, {2'b11, 14'h0001}, 32'hFFFF_0000, "R2 status");
        issue(OPC, 5'd0, {2'b00, 14'h3FFF}, 32'h0, "R7 set");
        issue(OPC, 5'b00001, {2'b00, 14'h3FFF}, 32'h0, "R8 clr");
        issue(OPC, 5'b00001, {2'b00, 14'h0F0F}, 32'h0, "R8 clr2");
        issue(OPC, 5'd0, {2'b00, 14'h1234}, 32'h0, "R7 set2");
        // R1: rejected encodings
        issue(6'b100100, 5'd0, {2'b11, 14'h0001}, 32'h1111_1111, "R1 major");
        issue(OPC, 5'd0, {2'b01, 14'h0001}, 32'h2222_2222, "R1 prefix");
        issue(OPC, 5'd3, {2'b10, 14'h0001}, 32'h0, "R1 midget");
        issue(OPC, 5'd2, {2'b00, 14'h00FF}, 32'h0, "R1 midbit");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [13:0] s;
            logic [5:0]  maj;
            r = $urandom % 20;
            s = (($urandom % 4) == 0) ? 14'($urandom) : pool[$urandom % 24];
            if (r == 0) begin
                maj = 6'($urandom);
                if (maj == OPC) maj = ~OPC;
                issue(maj, 5'd0, {2'b11, s}, $urandom, "R1 rnd");
            end
            else if (r == 1)  issue(OPC, 5'd0, {2'b01, s}, $urandom, "R1 rnd");
            else if (r == 2)  issue(OPC, 5'd3, {2'b10, s}, $urandom, "R1 rnd");
            else if (r < 9)   issue(OPC, 5'd0, {2'b11, s}, $urandom, "R2_R3 rnd");
            else if (r < 14)  issue(OPC, 5'd0, {2'b10, s}, $urandom, "R4_R5 rnd");
            else if (r < 16)  issue(OPC, 5'b01000, {2'b10, s}, $urandom, "R6 rnd");
            else if (r < 18)  issue(OPC, 5'd0, {2'b00, 14'($urandom)}, $urandom, "R7 rnd");
            else              issue(OPC, 5'b00001, {2'b00, 14'($urandom)}, $urandom, "R8 rnd");
        end

        repeat (2) @(negedge clk);
        chk("R9 idle we", {31'h0, o_rd_we}, 32'h0);
        chk("R9 idle rd", o_rd, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule